// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Victim Selector

This block keeps replacement history for a set-associative cache with eight ways per set. Each set has a seven-bit binary decision tree. Any access that lands on a way, whether it is a hit or a freshly filled line, steers the tree away from that way. When the cache controller needs a line to replace, the block names a victim way for the queried set. A way that is not valid is always chosen before the tree is consulted.

The controller drives a write side and a read side. The write side is an access strobe with a set index and the way number. The read side is a query set index and that set's eight valid bits. The victim comes out combinationally on the same cycle. Tag storage, line data and refill traffic belong to the surrounding cache.

Top module: `plru8_victim_sel`

## Requirements
- R1: While `rst_n` is low, every tree bit of every set is cleared. After reset, a query of any set with all eight valid bits set returns way 0.
- R2: With all valid bits set, the victim is decoded from the queried set's tree bits t0..t6 as follows. If t0=0, look at t1. When t1=0 the victim is way 1 if t3=1 and way 0 otherwise. When t1=1 the victim is way 3 if t4=1 and way 2 otherwise. If t0=1, look at t2. When t2=0 the victim is way 5 if t5=1 and way 4 otherwise. When t2=1 the victim is way 7 if t6=1 and way 6 otherwise.
- R3: When any bit of `qry_valid` is 0, the victim is the lowest-numbered way whose valid bit is 0, regardless of the tree. Bit n of `qry_valid` belongs to way n.
- R4: A clock edge with `acc_en` high writes three bits of the accessed set's tree, and the way number (w2 w1 w0) decides which. t0 gets ~w2. For ways 0-3, t1 gets ~w1, and then t3 (ways 0-1) or t4 (ways 2-3) gets ~w0. For ways 4-7, t2 gets ~w1, and then t5 (ways 4-5) or t6 (ways 6-7) gets ~w0. All other tree bits are kept.
- R5: An access changes only the tree of the set given by `acc_set`. The trees of all other sets are unchanged.
- R6: A clock edge with `acc_en` low changes no tree, whatever `acc_set` and `acc_way` hold.
- R7: A query in the same cycle as an access to the same set returns a victim computed from the tree as it was before that access. The new tree is seen from the next cycle on.
- R8: `victim_way` depends combinationally on `qry_set`, `qry_valid` and the stored trees. It changes in the same cycle as the query inputs, with no added register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| acc_en | input | 1 | Access strobe; updates the tree at the next rising edge |
| acc_set | input | 7 | Set index of the access |
| acc_way | input | 3 | Way number the access resolved to |
| qry_set | input | 7 | Set index of the victim query |
| qry_valid | input | 8 | Valid bits of the queried set, bit n for way n |
| victim_way | output | 3 | Selected victim way for the queried set |

## Verification
The properties assume that `qry_set` indexes an existing set and that the inputs carry no X after reset. The hold property assumes the query inputs stay on one set with all ways valid for two cycles in a row. The stimulus drives every input from a known value from time zero. It changes the inputs only at falling edges, and it holds the query set while the access strobe stays low, so that this hold window really occurs. It also ties the query set to the access set every few steps, so that the same-cycle read of an updated set and the steering check that follows it are both exercised.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAYS   = 8;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TREE_W = WAYS - 1;

  typedef logic [WAY_W-1:0]  way_idx_t;
  typedef logic [TREE_W-1:0] tree_bits_t;
  typedef logic [WAYS-1:0]   way_mask_t;
endpackage

// File: rtl/plru_touch_calc.sv
module plru_touch_calc
  import plru_pkg::*;
(
  input  tree_bits_t tree_in,
  input  way_idx_t   way,
  output tree_bits_t tree_out
);
  // Steer every tree level on the path away from the accessed way.
  always_comb begin
    tree_out    = tree_in;
    tree_out[0] = ~way[2];
    if (!way[2]) begin
      tree_out[1] = ~way[1];
      if (!way[1]) tree_out[3] = ~way[0];
      else         tree_out[4] = ~way[0];
    end else begin
      tree_out[2] = ~way[1];
      if (!way[1]) tree_out[5] = ~way[0];
      else         tree_out[6] = ~way[0];
    end
  end
endmodule

// File: rtl/plru_tree_decode.sv
module plru_tree_decode
  import plru_pkg::*;
(
  input  tree_bits_t tree,
  output way_idx_t   way
);
  always_comb begin
    if (tree[0]) begin
      way[2] = 1'b1;
      way[1] = tree[2];
      way[0] = tree[2] ? tree[6] : tree[5];
    end else begin
      way[2] = 1'b0;
      way[1] = tree[1];
      way[0] = tree[1] ? tree[4] : tree[3];
    end
  end
endmodule

// File: rtl/plru_hole_find.sv
module plru_hole_find
  import plru_pkg::*;
(
  input  way_mask_t valid,
  output logic      all_valid,
  output way_idx_t  hole_way
);
  always_comb begin
    all_valid = &valid;
    hole_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) hole_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/plru_tree_store.sv
module plru_tree_store
  import plru_pkg::*;
#(
  parameter int SETS  = 128,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  tree_bits_t       wr_tree,
  output tree_bits_t       wr_cur,
  input  logic [SET_W-1:0] rd_set,
  output tree_bits_t       rd_tree
);
  tree_bits_t tree_all [SETS];

  for (genvar s = 0; s < SETS; s++) begin : gen_set
    logic       set_we;
    tree_bits_t tree_q;

    always_comb begin
      set_we = wr_en && (wr_set == SET_W'(s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tree_q <= '0;
      end else if (set_we) begin
        tree_q <= wr_tree;
      end
    end

    assign tree_all[s] = tree_q;
  end

  assign wr_cur  = tree_all[wr_set];
  assign rd_tree = tree_all[rd_set];
endmodule

// File: rtl/plru8_victim_sel.sv
module plru8_victim_sel
  import plru_pkg::*;
#(
  parameter int SETS  = 128,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [SET_W-1:0] qry_set,
  input  logic [WAYS-1:0]  qry_valid,
  output logic [WAY_W-1:0] victim_way
);
  tree_bits_t cur_tree;
  tree_bits_t new_tree;
  tree_bits_t qry_tree;
  way_idx_t   tree_way;
  way_idx_t   hole_way;
  logic       all_valid;

  plru_tree_store #(.SETS(SETS)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_en),
    .wr_set  (acc_set),
    .wr_tree (new_tree),
    .wr_cur  (cur_tree),
    .rd_set  (qry_set),
    .rd_tree (qry_tree)
  );

  plru_touch_calc touch_i (
    .tree_in  (cur_tree),
    .way      (acc_way),
    .tree_out (new_tree)
  );

  plru_tree_decode decode_i (
    .tree (qry_tree),
    .way  (tree_way)
  );

  plru_hole_find hole_i (
    .valid     (qry_valid),
    .all_valid (all_valid),
    .hole_way  (hole_way)
  );

  assign victim_way = all_valid ? tree_way : hole_way;
endmodule

// File: rtl/plru8_victim_sel_chk.sv
module plru8_victim_sel_chk #(
  parameter int SETS  = 128,
  localparam int SET_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic [SET_W-1:0] acc_set,
  input logic [2:0]       acc_way,
  input logic [SET_W-1:0] qry_set,
  input logic [7:0]       qry_valid,
  input logic [2:0]       victim_way
);
  logic [7:0] below_victim;
  assign below_victim = (8'd1 << victim_way) - 8'd1;

  // R3: an invalid way is picked when one exists
  a_r3_hole_is_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid != 8'hFF) |-> !qry_valid[victim_way]);

  // R3: every way below the picked hole is valid
  a_r3_lowest_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid != 8'hFF) |-> ((qry_valid & below_victim) == below_victim));

  // R4: right after an access, the same set no longer names that way
  a_r4_steer_away: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> (!((&qry_valid) && (qry_set == $past(acc_set)))
                || (victim_way != $past(acc_way))));

  // R5 and R6: a set that was not written keeps its victim
  a_r5_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en || (acc_set != qry_set)) |=>
      (!((&qry_valid) && $stable(qry_valid) && $stable(qry_set))
       || $stable(victim_way)));
endmodule

bind plru8_victim_sel plru8_victim_sel_chk #(.SETS(SETS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_set    (acc_set),
  .acc_way    (acc_way),
  .qry_set    (qry_set),
  .qry_valid  (qry_valid),
  .victim_way (victim_way)
);

// File: tb/plru8_victim_sel_tb_top.sv
module plru8_victim_sel_tb_top;
  localparam int SETS = 128;

  logic       clk;
  logic       rst_n;
  logic       acc_en;
  logic [6:0] acc_set;
  logic [2:0] acc_way;
  logic [6:0] qry_set;
  logic [7:0] qry_valid;
  logic [2:0] victim_way;

  int n_checks;
  int n_fails;
  int cycles;
  logic [6:0]  mdl [SETS];
  logic [31:0] rng;

  plru8_victim_sel #(.SETS(SETS)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_set    (acc_set),
    .acc_way    (acc_way),
    .qry_set    (qry_set),
    .qry_valid  (qry_valid),
    .victim_way (victim_way)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected tree after an access: bits to write and their new values.
  function automatic logic [6:0] m_touch(logic [6:0] t, logic [2:0] w);
    logic [6:0] msk;
    logic [6:0] val;
    case (w)
      3'd0: begin msk = 7'd11; val = 7'd11; end
      3'd1: begin msk = 7'd11; val = 7'd3;  end
      3'd2: begin msk = 7'd19; val = 7'd17; end
      3'd3: begin msk = 7'd19; val = 7'd1;  end
      3'd4: begin msk = 7'd37; val = 7'd36; end
      3'd5: begin msk = 7'd37; val = 7'd4;  end
      3'd6: begin msk = 7'd69; val = 7'd64; end
      default: begin msk = 7'd69; val = 7'd0; end
    endcase
    return (t & ~msk) | val;
  endfunction

  function automatic logic [2:0] m_pick(logic [6:0] t, logic [7:0] v);
    if (v != 8'hFF) begin
      for (int w = 7; w >= 0; w--) begin
        if (!v[w]) m_pick = 3'(w);
      end
      return m_pick;
    end
    if (t[0]) begin
      if (t[2]) return t[6] ? 3'd7 : 3'd6;
      else      return t[5] ? 3'd5 : 3'd4;
    end else begin
      if (t[1]) return t[4] ? 3'd3 : 3'd2;
      else      return t[3] ? 3'd1 : 3'd0;
    end
  endfunction

  task automatic next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  // Called at a falling edge: drive, check before the rising edge, then advance.
  task automatic step(input logic en, input logic [6:0] aset, input logic [2:0] away,
                      input logic [6:0] qset, input logic [7:0] qv, input string tag);
    logic [2:0] exp_w;
    acc_en    = en;
    acc_set   = aset;
    acc_way   = away;
    qry_set   = qset;
    qry_valid = qv;
    #2;
    exp_w = m_pick(mdl[qset], qv);
    n_checks++;
    if (victim_way !== exp_w) begin
      n_fails++;
      $display("FAIL %s set=%0d valid=%h got=%0d expected=%0d", tag, qset, qv, victim_way, exp_w);
    end
    @(posedge clk);
    if (en) mdl[aset] = m_touch(mdl[aset], away);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog got=%0d expected<=150000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    rng       = 32'h1234_5679;
    rst_n     = 1'b0;
    acc_en    = 1'b0;
    acc_set   = '0;
    acc_way   = '0;
    qry_set   = '0;
    qry_valid = 8'hFF;
    for (int s = 0; s < SETS; s++) mdl[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every set starts from the cleared tree
    for (int s = 0; s < SETS; s++) step(1'b0, 7'd0, 3'd0, 7'(s), 8'hFF, "R1");

    // R3: all valid masks on one set, lowest invalid way wins
    for (int m = 0; m < 256; m++) step(1'b0, 7'd0, 3'd0, 7'd5, 8'(m), "R3");

    // R4 / R2: walk all ways on one set, then the reverse order
    for (int w = 0; w < 8; w++) step(1'b1, 7'd3, 3'(w), 7'd3, 8'hFF, "R7");
    step(1'b0, 7'd0, 3'd0, 7'd3, 8'hFF, "R4");
    for (int w = 7; w >= 0; w--) begin
      step(1'b1, 7'd3, 3'(w), 7'd4, 8'hFF, "R5");
      step(1'b0, 7'd0, 3'd0, 7'd3, 8'hFF, "R4");
    end

    // R2: every pair of consecutive ways on a fresh set, decode after each
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        step(1'b1, 7'd20, 3'(a), 7'd21, 8'hFF, "R5");
        step(1'b1, 7'd20, 3'(b), 7'd20, 8'hFF, "R7");
        step(1'b0, 7'd0, 3'd0, 7'd20, 8'hFF, "R2");
      end
    end

    // R6: strobe low with busy access fields, query held on one set
    for (int i = 0; i < 64; i++) begin
      next_rng();
      step(1'b0, 7'd3, rng[2:0], 7'd3, 8'hFF, "R6");
    end

    // R8 / R5 / R7: mixed traffic over all sets, query follows in the same cycle
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] as;
      logic [6:0] qs;
      logic [7:0] qv;
      next_rng();
      as = rng[6:0];
      qs = (i % 4 == 0) ? as : rng[13:7];
      qv = (rng[20:18] == 3'd0) ? rng[31:24] : 8'hFF;
      step(rng[14] | rng[15], as, rng[17:15], qs, qv,
           (qs == as) ? "R7" : ((qv != 8'hFF) ? "R3" : "R8"));
    end

    // R2: sweep the final state of every set
    for (int s = 0; s < SETS; s++) step(1'b0, 7'd0, 3'd0, 7'(s), 8'hFF, "R2");

    // R1: reset again clears state left by traffic
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < SETS; s++) mdl[s] = '0;
    @(negedge clk);
    for (int s = 0; s < SETS; s += 9) step(1'b0, 7'd0, 3'd0, 7'(s), 8'hFF, "R1");

    finish_run();
  end
endmodule